// File: doc/BRIEF.md
# Micro-frame Index Counter

This block keeps the free-running frame index of a host controller that walks a periodic schedule. The index advances by one on every micro-frame tick (one tick per 125 us micro-frame) while the controller is running. It holds while the controller is halted. Software reaches the index through a 32-bit word port. The 14-bit count sits in the low bits of that word, and the upper bits read as zero.

Bits N down to 3 of the count choose the entry in the periodic frame list. N comes from a programmable list-size selector. The block presents that slice, zero-extended, as the list-entry select. It raises a one-cycle rollover pulse when the slice wraps from all ones to zero. It also exports a start-of-frame number taken from count bits 13 down to 3, so any write to the count moves that number as well.

Writes take effect only while the controller is halted and only when all four byte enables are set. Any other write leaves the count untouched.

Top module: `uframe_index_ctr`

## Requirements
- R1: After reset the count is zero, `rd_data` is zero, `rollover` is low and `sof_num` is zero.
- R2: While `halted` is low, each cycle with `uframe_tick` high raises the 14-bit count by one, wrapping from 0x3FFF to 0. The new value is visible after that clock edge.
- R3: While `halted` is high, `uframe_tick` has no effect on the count.
- R4: A write with `wr_en` high, `halted` high and `wr_be` equal to 4'b1111 loads `wr_data[13:0]` into the count on that clock edge.
- R5: A write with any byte enable low is dropped, and the count keeps its value.
- R6: A write while `halted` is low is dropped. The count follows R2 only.
- R7: `rd_data` returns the count in bits 13:0, and bits 31:14 read as zero.
- R8: The list-size code sets N: code 0 gives 1024 entries (N=12), code 1 gives 512 entries (N=11), code 2 gives 256 entries (N=10), and code 3 is treated like code 0. `list_entry` equals count bits N:3, zero-extended to 10 bits.
- R9: `rollover` is high for exactly the one cycle that follows a tick-driven increment in which count bits N:0 went from all ones to zero. Loading the count through a write never raises it.
- R10: `sof_num` equals count bits 13:3 at all times, including right after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_tick | input | 1 | One-cycle pulse per micro-frame |
| halted | input | 1 | High while the controller is halted |
| list_size | input | 2 | Frame-list size code (0=1024, 1=512, 2=256, 3 as 0) |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read view of the index register |
| frame_index | output | 14 | Current count |
| list_entry | output | 10 | Periodic list entry select |
| rollover | output | 1 | One-cycle pulse on list wrap |
| sof_num | output | 11 | Start-of-frame number |

## Verification
The embedded assertions check on every cycle that the count holds while halted unless a full write lands, that a running tick adds exactly one, that partial or running writes never alter the count, and that a rollover pulse always follows a running tick and lands on a zeroed list slice. Only the bench scenarios can show which sizes produce a rollover at which counts, that the reserved size code behaves like the largest list, and that loaded values appear on the read word and the start-of-frame number.

// File: rtl/uframe_pkg.sv
package uframe_pkg;

   typedef enum logic [1:0] {
      LSZ_1024 = 2'd0,
      LSZ_512  = 2'd1,
      LSZ_256  = 2'd2,
      LSZ_RSVD = 2'd3
   } list_size_e;

   // number of selectable list sizes (reserved code aliases the largest)
   localparam int unsigned NUM_SIZES = 3;

   function automatic int unsigned size_slot(input list_size_e code);
      case (code)
         LSZ_512:  return 1;
         LSZ_256:  return 2;
         default:  return 0;
      endcase
   endfunction

endpackage

// File: rtl/ufi_wr_gate.sv
module ufi_wr_gate #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 14,
   localparam int unsigned BE_W  = DATA_W / 8
) (
   input  logic              wr_en,
   input  logic [BE_W-1:0]   wr_be,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              halted,
   output logic              take,
   output logic [CNT_W-1:0]  take_val
);

   if ((DATA_W % 8) != 0) begin : g_bad_data_w
      $error("ufi_wr_gate: DATA_W must be a whole number of bytes");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("ufi_wr_gate: CNT_W may not exceed DATA_W");
   end

   logic full_word;

   assign full_word = &wr_be;
   assign take      = wr_en & halted & full_word;
   assign take_val  = wr_data[CNT_W-1:0];

endmodule

// File: rtl/ufi_count_core.sv
module ufi_count_core #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             adv,
   output logic [CNT_W-1:0] count
);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("ufi_count_core: CNT_W too small");
   end

   logic [CNT_W-1:0] count_d;

   always_comb begin
      count_d = count;
      if (load)
         count_d = load_val;
      else if (adv)
         count_d = count + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else
         count <= count_d;
   end

   // R2
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !load) |=> (count == $past(count) + CNT_W'(1)));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load) |=> $stable(count));

endmodule

// File: rtl/ufi_list_select.sv
module ufi_list_select
   import uframe_pkg::*;
#(
   parameter int unsigned CNT_W     = 14,
   parameter int unsigned SEL_LSB   = 3,
   parameter int unsigned MAX_LOG2  = 10,
   localparam int unsigned MAX_N    = SEL_LSB + MAX_LOG2 - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CNT_W-1:0]    count,
   input  logic [1:0]          list_size,
   input  logic                adv,
   output logic [MAX_LOG2-1:0] list_entry,
   output logic                rollover
);

   if (MAX_N >= CNT_W) begin : g_bad_span
      $error("ufi_list_select: list slice exceeds the counter");
   end
   if (MAX_LOG2 < NUM_SIZES) begin : g_bad_log2
      $error("ufi_list_select: MAX_LOG2 too small for the size codes");
   end

   logic [MAX_LOG2-1:0] cand   [NUM_SIZES];
   logic [NUM_SIZES-1:0] full_ones;
   int unsigned          slot;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int unsigned TOP = MAX_N - s;
      localparam int unsigned W   = TOP - SEL_LSB + 1;
      if (s == 0) begin : g_full
         assign cand[s] = count[TOP:SEL_LSB];
      end else begin : g_pad
         assign cand[s] = {{s{1'b0}}, count[TOP:SEL_LSB]};
      end
      assign full_ones[s] = &count[TOP:0];
      if (W + s != MAX_LOG2) begin : g_bad_w
         $error("ufi_list_select: slice width mismatch");
      end
   end

   assign slot       = size_slot(list_size_e'(list_size));
   assign list_entry = cand[slot];

   always_ff @(posedge clk) begin
      if (!rst_n)
         rollover <= 1'b0;
      else
         rollover <= adv & full_ones[slot];
   end

   // R9
   rollover_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rollover |-> $past(adv));

   // R9
   rollover_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rollover && $stable(list_size)) |-> (list_entry == '0));

endmodule

// File: rtl/uframe_index_ctr.sv
module uframe_index_ctr #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 14,
   parameter int unsigned SEL_LSB  = 3,
   parameter int unsigned MAX_LOG2 = 10,
   localparam int unsigned BE_W    = DATA_W / 8,
   localparam int unsigned SOF_W   = CNT_W - SEL_LSB
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                uframe_tick,
   input  logic                halted,
   input  logic [1:0]          list_size,
   input  logic                wr_en,
   input  logic [BE_W-1:0]     wr_be,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   rd_data,
   output logic [CNT_W-1:0]    frame_index,
   output logic [MAX_LOG2-1:0] list_entry,
   output logic                rollover,
   output logic [SOF_W-1:0]    sof_num
);

   if (SEL_LSB == 0 || SEL_LSB >= CNT_W) begin : g_bad_lsb
      $error("uframe_index_ctr: SEL_LSB out of range");
   end

   logic             take;
   logic [CNT_W-1:0] take_val;
   logic             adv;
   logic [CNT_W-1:0] count;

   assign adv = uframe_tick & ~halted;

   ufi_wr_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_gate (
      .wr_en    (wr_en),
      .wr_be    (wr_be),
      .wr_data  (wr_data),
      .halted   (halted),
      .take     (take),
      .take_val (take_val)
   );

   ufi_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take),
      .load_val (take_val),
      .adv      (adv),
      .count    (count)
   );

   ufi_list_select #(
      .CNT_W    (CNT_W),
      .SEL_LSB  (SEL_LSB),
      .MAX_LOG2 (MAX_LOG2)
   ) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .count      (count),
      .list_size  (list_size),
      .adv        (adv),
      .list_entry (list_entry),
      .rollover   (rollover)
   );

   assign frame_index = count;
   assign sof_num     = count[CNT_W-1:SEL_LSB];
   assign rd_data     = {{(DATA_W-CNT_W){1'b0}}, count};

   // R5
   partial_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && halted && wr_be != '1) |=> $stable(frame_index));

   // R6
   running_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !halted && !uframe_tick) |=> $stable(frame_index));

   // R4
   full_write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && halted && wr_be == '1) |=> (frame_index == $past(wr_data[CNT_W-1:0])));

endmodule

// File: tb/tb_uframe_index_ctr.sv
module tb_uframe_index_ctr;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        uframe_tick;
   logic        halted;
   logic [1:0]  list_size;
   logic        wr_en;
   logic [3:0]  wr_be;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic [13:0] frame_index;
   logic [9:0]  list_entry;
   logic        rollover;
   logic [10:0] sof_num;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   uframe_index_ctr dut (
      .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick), .halted(halted),
      .list_size(list_size), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
      .rd_data(rd_data), .frame_index(frame_index), .list_entry(list_entry),
      .rollover(rollover), .sof_num(sof_num)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      wr_en = 1'b1; wr_be = be; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_be = '0;
   endtask

   // one tick; returns at the next negedge with rollover of that step visible
   task automatic tick1(output logic roll);
      @(negedge clk);
      uframe_tick = 1'b1;
      @(negedge clk);
      uframe_tick = 1'b0;
      roll = rollover;
   endtask

   task automatic t_reset;
      chk("R1 count", {18'b0, frame_index}, 32'h0);
      chk("R1 rd_data", rd_data, 32'h0);
      chk("R1 rollover", {31'b0, rollover}, 32'h0);
      chk("R1 sof", {21'b0, sof_num}, 32'h0);
   endtask

   task automatic t_full_write;
      halted = 1'b1;
      do_write(32'hFFFF_2A5D, 4'hF);
      chk("R4 load", {18'b0, frame_index}, 32'h2A5D);
      chk("R7 rd_data upper zero", rd_data, 32'h0000_2A5D);
      chk("R10 sof after write", {21'b0, sof_num}, 32'h2A5D >> 3);
      chk("R9 no rollover on load", {31'b0, rollover}, 32'h0);
   endtask

   task automatic t_partial_write;
      halted = 1'b1;
      do_write(32'h0000_0123, 4'b0111);
      chk("R5 be 0111", {18'b0, frame_index}, 32'h2A5D);
      do_write(32'h0000_0456, 4'b1110);
      chk("R5 be 1110", {18'b0, frame_index}, 32'h2A5D);
   endtask

   task automatic t_halt_hold;
      logic r;
      halted = 1'b1;
      for (int i = 0; i < 3; i++) tick1(r);
      chk("R3 halted ticks", {18'b0, frame_index}, 32'h2A5D);
   endtask

   task automatic t_run_count;
      logic r;
      halted = 1'b1;
      do_write(32'h0000_0100, 4'hF);
      halted = 1'b0;
      for (int i = 0; i < 5; i++) tick1(r);
      chk("R2 five ticks", {18'b0, frame_index}, 32'h105);
      repeat (3) @(negedge clk);
      chk("R2 no tick holds", {18'b0, frame_index}, 32'h105);
      do_write(32'h0000_3333, 4'hF);
      chk("R6 running write dropped", {18'b0, frame_index}, 32'h105);
   endtask

   task automatic t_roll(input logic [1:0] sz, input logic [13:0] start,
                         input logic exp_roll, input logic [9:0] exp_entry, input string tag);
      logic r;
      halted = 1'b1;
      list_size = sz;
      do_write({18'b0, start}, 4'hF);
      halted = 1'b0;
      tick1(r);
      chk({"R9 rollover ", tag}, {31'b0, r}, {31'b0, exp_roll});
      chk({"R8 entry ", tag}, {22'b0, list_entry}, {22'b0, exp_entry});
      chk({"R10 sof ", tag}, {21'b0, sof_num}, {21'b0, 11'((start + 14'd1) >> 3)});
      @(negedge clk);
      chk({"R9 pulse one cycle ", tag}, {31'b0, rollover}, 32'h0);
   endtask

   task automatic t_entry_slices;
      halted = 1'b1;
      do_write(32'h0000_3FF8, 4'hF);
      list_size = 2'd0;
      #1 chk("R8 size0 slice", {22'b0, list_entry}, 32'h3FF);
      list_size = 2'd1;
      #1 chk("R8 size1 slice", {22'b0, list_entry}, 32'h1FF);
      list_size = 2'd2;
      #1 chk("R8 size2 slice", {22'b0, list_entry}, 32'h0FF);
      list_size = 2'd3;
      #1 chk("R8 size3 as size0", {22'b0, list_entry}, 32'h3FF);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; uframe_tick = 1'b0; halted = 1'b1; list_size = 2'd0;
      wr_en = 1'b0; wr_be = '0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_write();
      t_partial_write();
      t_halt_hold();
      t_run_count();
      t_roll(2'd0, 14'h1FFF, 1'b1, 10'h000, "size0 wrap");
      t_roll(2'd0, 14'h0FFF, 1'b0, 10'h200, "size0 mid");
      t_roll(2'd1, 14'h0FFF, 1'b1, 10'h000, "size1 wrap");
      t_roll(2'd2, 14'h07FF, 1'b1, 10'h000, "size2 wrap");
      t_roll(2'd2, 14'h03FF, 1'b0, 10'h080, "size2 mid");
      t_roll(2'd3, 14'h0FFF, 1'b0, 10'h200, "size3 as size0");
      t_roll(2'd0, 14'h3FFF, 1'b1, 10'h000, "R2 full wrap");
      t_entry_slices();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule